// File: doc/BRIEF.md
# Dual-Half NAND Page Parity Generator

This block sits beside the byte path of a NAND flash controller and builds Hamming-style parity over a 512-byte page as the bytes move through. The page is split into two 256-byte halves. Each half keeps its own line-parity word and column-parity field. Software steers the block by writing one of three mode codes. The first code clears the accumulators. The second makes every following byte transfer count towards the parity. The third turns reads of the data register into reads of the result.

The six parity bytes come out as three 16-bit words, with the bytes of the two halves interleaved in a fixed order. When the block is not in readout mode, and after the third result word has been read, the data-register read returns the ordinary 16-bit word from the flash. Correcting the data is not part of this block.

Top module: `nand_ecc_gen`

## Requirements
- R1: Writing mode code 0xF4 clears both halves' accumulators, the page byte count and the result pointer, so the next three result words read 0xFFFF each.
- R2: A byte with `dat_vld` high counts only while the mode is 0xB4. Bytes transferred under any other mode have no effect on the result. This covers the dummy read that follows a clear.
- R3: Each half keeps 16 line-parity bits. For each bit k of the byte's index within its half, the byte's overall parity is XORed into LP(2k+1) when the index bit is 1 and into LP(2k) when it is 0.
- R4: Each half keeps six column parities. CP0 covers data bits {0,2,4,6}, CP1 covers {1,3,5,7}, CP2 covers {0,1,4,5}, CP3 covers {2,3,6,7}, CP4 covers {0..3} and CP5 covers {4..7}. The column byte holds CP5..CP0 in bits 7:2, and its bits 1:0 always read 1.
- R5: Every parity bit is returned inverted. A page of all 0x00 or all 0xFF therefore reads 0xFFFF in all three result words.
- R6: Counted bytes 0..255 after a clear go to half A and bytes 256..511 go to half B. Further counted bytes are ignored until the next clear.
- R7: In mode 0xD4, successive reads return three words in this order. Word 0 is {A LP15..8, A LP7..0}. Word 1 is {B LP7..0, A column byte}. Word 2 is {B column byte, B LP15..8}. In each word the high byte is listed first.
- R8: After the third result word, further reads in mode 0xD4 return `nand_word`, and the pointer stays exhausted.
- R9: Outside mode 0xD4 a read returns `nand_word` and leaves the result pointer where it was. Re-entering 0xD4 continues from the word that was next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_wr | input | 1 | Mode register write strobe |
| mode_din | input | 8 | Mode code written |
| dat_vld | input | 1 | One data byte is transferred this cycle |
| dat_byte | input | 8 | The byte being transferred |
| rd_strobe | input | 1 | Data-register read happens this cycle |
| nand_word | input | 16 | Ordinary read data from the flash side |
| rd_word | output | 16 | Data-register read value (result word or flash data) |

## Verification
A wrong accumulator bit shows up at the very next readout as one flipped bit in exactly one result byte. Which byte it lands in tells whether the line field or the column field is wrong, and for which half. A miscounted byte position sends parity into the wrong half or the wrong LP pair. This can be seen from a page with a single nonzero byte at the first index, and another at the last. A bad result pointer shows up on the first read after a mode change: a word is skipped or repeated, or flash data appears where a result word belongs.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;

   localparam logic [7:0] MODE_ECC_CLR = 8'hF4;
   localparam logic [7:0] MODE_ECC_RUN = 8'hB4;
   localparam logic [7:0] MODE_ECC_OUT = 8'hD4;

   typedef enum logic [1:0] {
      ST_PASS = 2'd0,
      ST_RUN  = 2'd1,
      ST_OUT  = 2'd2
   } ecc_state_e;

   // Six column-parity terms of one byte (group masks of bit positions)
   function automatic logic [5:0] col_terms(input logic [7:0] b);
      logic [5:0] c;
      c[0] = b[0] ^ b[2] ^ b[4] ^ b[6];
      c[1] = b[1] ^ b[3] ^ b[5] ^ b[7];
      c[2] = b[0] ^ b[1] ^ b[4] ^ b[5];
      c[3] = b[2] ^ b[3] ^ b[6] ^ b[7];
      c[4] = ^b[3:0];
      c[5] = ^b[7:4];
      return c;
   endfunction

endpackage

// File: rtl/ecc_half_acc.sv
module ecc_half_acc
   import nand_ecc_pkg::*;
#(
   parameter int IDX_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             en,
   input  logic [IDX_W-1:0] idx,
   input  logic [7:0]       din,
   output logic [7:0]       par_lo,
   output logic [7:0]       par_hi,
   output logic [7:0]       par_col
);

   localparam int LP_W = 2 * IDX_W;

   logic [LP_W-1:0] lp_q, lp_d;
   logic [5:0]      cp_q;
   logic            byte_par;
   logic [15:0]     lp_pad;

   assign byte_par = ^din;

   // Line parity: pair per index bit, odd slot for a 1, even slot for a 0
   for (genvar k = 0; k < IDX_W; k++) begin : g_lp
      assign lp_d[2*k]   = lp_q[2*k]   ^ (byte_par & ~idx[k]);
      assign lp_d[2*k+1] = lp_q[2*k+1] ^ (byte_par &  idx[k]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lp_q <= '0;
         cp_q <= '0;
      end else if (clr) begin
         lp_q <= '0;
         cp_q <= '0;
      end else if (en) begin
         lp_q <= lp_d;
         cp_q <= cp_q ^ col_terms(din);
      end
   end

   always_comb begin
      lp_pad = '0;
      lp_pad[LP_W-1:0] = lp_q;
   end

   // Stored parities leave inverted
   assign par_lo  = ~lp_pad[7:0];
   assign par_hi  = ~lp_pad[15:8];
   assign par_col = {~cp_q, 2'b11};

endmodule

// File: rtl/ecc_mode_ctrl.sv
module ecc_mode_ctrl
   import nand_ecc_pkg::*;
#(
   parameter int HALF_BYTES = 256
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mode_wr,
   input  logic [7:0]       mode_din,
   input  logic             dat_vld,
   input  logic             rd_strobe,
   output logic             clr,
   output logic [1:0]       acc_en,
   output logic [$clog2(HALF_BYTES)-1:0] acc_idx,
   output logic [1:0]       res_sel,
   output logic             res_act
);

   localparam int IDX_W = $clog2(HALF_BYTES);
   localparam int CNT_W = IDX_W + 2;
   localparam logic [CNT_W-1:0] TOTAL = CNT_W'(2 * HALF_BYTES);

   ecc_state_e       st_q;
   logic [CNT_W-1:0] cnt_q;
   logic [1:0]       rptr_q;
   logic             acc_go;

   assign clr     = mode_wr && (mode_din == MODE_ECC_CLR);
   assign acc_go  = (st_q == ST_RUN) && dat_vld && (cnt_q < TOTAL);
   assign acc_en  = {acc_go & cnt_q[IDX_W], acc_go & ~cnt_q[IDX_W]};
   assign acc_idx = cnt_q[IDX_W-1:0];
   assign res_act = (st_q == ST_OUT) && (rptr_q != 2'd3);
   assign res_sel = rptr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= ST_PASS;
      end else if (mode_wr) begin
         case (mode_din)
            MODE_ECC_RUN: st_q <= ST_RUN;
            MODE_ECC_OUT: st_q <= ST_OUT;
            default:      st_q <= ST_PASS;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         rptr_q <= '0;
      end else if (clr) begin
         cnt_q  <= '0;
         rptr_q <= '0;
      end else begin
         if (acc_go)
            cnt_q <= cnt_q + 1'b1;
         if (rd_strobe && res_act)
            rptr_q <= rptr_q + 1'b1;
      end
   end

   // R6: page counter never runs past one page
   a_r6_cnt_cap: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= TOTAL);

   // R9: reads outside readout leave the pointer alone
   a_r9_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_strobe && st_q != ST_OUT && !clr) |=> $stable(rptr_q));

   // R8: an exhausted pointer stays exhausted until a clear
   a_r8_ptr_end: assert property (@(posedge clk) disable iff (!rst_n)
      (rptr_q == 2'd3 && !clr) |=> (rptr_q == 2'd3));

endmodule

// File: rtl/ecc_result_mux.sv
module ecc_result_mux (
   input  logic [15:0] word0,
   input  logic [15:0] word1,
   input  logic [15:0] word2,
   input  logic [1:0]  res_sel,
   input  logic        res_act,
   input  logic [15:0] nand_word,
   output logic [15:0] rd_word
);

   always_comb begin
      rd_word = nand_word;
      if (res_act) begin
         case (res_sel)
            2'd0:    rd_word = word0;
            2'd1:    rd_word = word1;
            2'd2:    rd_word = word2;
            default: rd_word = nand_word;
         endcase
      end
   end

endmodule

// File: rtl/nand_ecc_gen.sv
module nand_ecc_gen #(
   parameter int HALF_BYTES = 256
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        mode_wr,
   input  logic [7:0]  mode_din,
   input  logic        dat_vld,
   input  logic [7:0]  dat_byte,
   input  logic        rd_strobe,
   input  logic [15:0] nand_word,
   output logic [15:0] rd_word
);

   localparam int IDX_W  = $clog2(HALF_BYTES);
   localparam int HALVES = 2;

   if (HALF_BYTES < 2 || HALF_BYTES > 256 ||
       (HALF_BYTES & (HALF_BYTES - 1)) != 0) begin : g_bad_half
      $error("HALF_BYTES must be a power of two from 2 to 256");
   end

   logic             clr, res_act;
   logic [1:0]       acc_en, res_sel;
   logic [IDX_W-1:0] acc_idx;
   logic [7:0]       p_lo  [HALVES];
   logic [7:0]       p_hi  [HALVES];
   logic [7:0]       p_col [HALVES];
   logic [15:0]      word0, word1, word2;

   ecc_mode_ctrl #(.HALF_BYTES(HALF_BYTES)) ctrl_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode_wr   (mode_wr),
      .mode_din  (mode_din),
      .dat_vld   (dat_vld),
      .rd_strobe (rd_strobe),
      .clr       (clr),
      .acc_en    (acc_en),
      .acc_idx   (acc_idx),
      .res_sel   (res_sel),
      .res_act   (res_act)
   );

   for (genvar h = 0; h < HALVES; h++) begin : g_half
      ecc_half_acc #(.IDX_W(IDX_W)) acc_i (
         .clk     (clk),
         .rst_n   (rst_n),
         .clr     (clr),
         .en      (acc_en[h]),
         .idx     (acc_idx),
         .din     (dat_byte),
         .par_lo  (p_lo[h]),
         .par_hi  (p_hi[h]),
         .par_col (p_col[h])
      );
   end

   // Interleaved readout order (R7)
   assign word0 = {p_hi[0],  p_lo[0]};
   assign word1 = {p_lo[1],  p_col[0]};
   assign word2 = {p_col[1], p_hi[1]};

   ecc_result_mux mux_i (
      .word0     (word0),
      .word1     (word1),
      .word2     (word2),
      .res_sel   (res_sel),
      .res_act   (res_act),
      .nand_word (nand_word),
      .rd_word   (rd_word)
   );

   // R1: a clear leaves every result word at all ones
   a_r1_clear_ones: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (word0 == 16'hFFFF && word1 == 16'hFFFF && word2 == 16'hFFFF));

   // R2: with no counted byte, results do not move
   a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && acc_en == 2'b00) |=> ($stable(word0) && $stable(word1) && $stable(word2)));

   // R6: at most one half is updated per byte
   a_r6_one_half: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(acc_en));

   // R4: low two bits of each column byte are ones
   a_r4_col_ones: assert property (@(posedge clk) disable iff (!rst_n)
      (word1[1:0] == 2'b11 && word2[9:8] == 2'b11));

endmodule

// File: tb/nand_ecc_gen_tb.sv
module nand_ecc_gen_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mode_wr = 1'b0;
   logic [7:0]  mode_din = 8'h00;
   logic        dat_vld = 1'b0;
   logic [7:0]  dat_byte = 8'h00;
   logic        rd_strobe = 1'b0;
   logic [15:0] nand_word = 16'hC3A5;
   logic [15:0] rd_word;

   int n_tests = 0;
   int n_fail  = 0;
   logic [7:0] pg [512];

   // pattern table: {multiplier, offset}; byte j = j*mul + off + j[8]*0x33
   localparam logic [15:0] VEC [6] = '{
      16'h0000, 16'h00FF, 16'h0100, 16'h035A, 16'h1107, 16'hC53C
   };

   always #5ns clk = ~clk;

   nand_ecc_gen dut_i (
      .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_din(mode_din),
      .dat_vld(dat_vld), .dat_byte(dat_byte), .rd_strobe(rd_strobe),
      .nand_word(nand_word), .rd_word(rd_word)
   );

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   task automatic set_mode(input logic [7:0] v);
      @(negedge clk); mode_wr = 1'b1; mode_din = v;
      @(negedge clk); mode_wr = 1'b0;
   endtask

   task automatic send(input logic [7:0] b);
      @(negedge clk); dat_vld = 1'b1; dat_byte = b;
      @(negedge clk); dat_vld = 1'b0;
   endtask

   task automatic rd(output logic [15:0] w);
      @(negedge clk); rd_strobe = 1'b1; #1ns; w = rd_word;
      @(negedge clk); rd_strobe = 1'b0;
   endtask

   // Independent model: loops over bits, per the requirement text
   function automatic logic [47:0] model();
      logic [15:0] lp [2];
      logic [5:0]  cp [2];
      logic [7:0]  cb [2];
      for (int h = 0; h < 2; h++) begin
         lp[h] = '0; cp[h] = '0;
         for (int j = 0; j < 256; j++) begin
            logic [7:0] b;
            logic p;
            b = pg[h*256 + j];
            p = ^b;
            for (int k = 0; k < 8; k++)
               if (((j >> k) & 1) == 1) lp[h][2*k+1] ^= p; else lp[h][2*k] ^= p;
            for (int t = 0; t < 8; t++)
               if (b[t]) begin
                  cp[h][0 + ((t >> 0) & 1)] ^= 1'b1;
                  cp[h][2 + ((t >> 1) & 1)] ^= 1'b1;
                  cp[h][4 + ((t >> 2) & 1)] ^= 1'b1;
               end
         end
         lp[h] = ~lp[h];
         cb[h] = {~cp[h], 2'b11};
      end
      return {cb[1], lp[1][15:8], lp[1][7:0], cb[0], lp[0][15:8], lp[0][7:0]};
   endfunction

   task automatic load_page(input logic [7:0] dummy);
      logic [15:0] w;
      set_mode(8'hF4);
      send(dummy);                // byte under clear mode: ignored (R2)
      rd(w);
      chk("R2 dummy read", w, nand_word);
      set_mode(8'hB4);
      for (int j = 0; j < 512; j++) send(pg[j]);
   endtask

   task automatic read3(input string tag, input logic [15:0] e0, e1, e2);
      logic [15:0] w;
      set_mode(8'hD4);
      rd(w); chk({tag, " R7 w0"}, w, e0);
      rd(w); chk({tag, " R7 w1"}, w, e1);
      rd(w); chk({tag, " R7 w2"}, w, e2);
      rd(w); chk({tag, " R8 4th"}, w, nand_word);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      logic [15:0] w;
      logic [47:0] m;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // Reset state: pass-through and all-ones results (R9, R1, R5)
      rd(w); chk("R9 reset pass", w, nand_word);
      read3("reset R1", 16'hFFFF, 16'hFFFF, 16'hFFFF);

      // Table-driven pages (R3, R4, R5, R6, R7)
      for (int v = 0; v < 6; v++) begin
         for (int j = 0; j < 512; j++)
            pg[j] = 8'(j * VEC[v][15:8] + VEC[v][7:0] + ((j >> 8) * 8'h33));
         if (v < 2) for (int j = 0; j < 512; j++) pg[j] = VEC[v][7:0];
         nand_word = 16'h1000 + 16'(v);
         load_page(8'hA5);
         m = model();
         read3($sformatf("vec%0d R3 R4 R5", v),
               {m[15:8], m[7:0]}, {m[31:24], m[23:16]}, {m[47:40], m[39:32]});
      end

      // Hand case: 0x01 at index 0 of half A (R3, R4)
      for (int j = 0; j < 512; j++) pg[j] = 8'h00;
      pg[0] = 8'h01;
      load_page(8'hFF);
      read3("first byte R3 R4", 16'hAAAA, 16'hFFAB, 16'hFFFF);

      // Hand case: 0x80 at last byte, half B (R6)
      pg[0] = 8'h00; pg[511] = 8'h80;
      load_page(8'h01);
      read3("last byte R6", 16'hFFFF, 16'h55FF, 16'h5755);

      // Extra byte past the page is ignored (R6)
      pg[511] = 8'h00;
      load_page(8'h00);
      send(8'h01);
      read3("overflow R6", 16'hFFFF, 16'hFFFF, 16'hFFFF);

      // Pointer pause across a mode change (R9) and exhaustion (R8)
      pg[0] = 8'h01;
      load_page(8'h00);
      set_mode(8'hD4);
      rd(w); chk("R9 w0", w, 16'hAAAA);
      set_mode(8'h94);
      rd(w); chk("R9 pass read", w, nand_word);
      set_mode(8'hD4);
      rd(w); chk("R9 resume w1", w, 16'hFFAB);
      rd(w); chk("R9 w2", w, 16'hFFFF);
      rd(w); chk("R8 4th", w, nand_word);
      rd(w); chk("R8 5th", w, nand_word);

      // Clear after data, then readout (R1)
      set_mode(8'hF4);
      read3("clear R1", 16'hFFFF, 16'hFFFF, 16'hFFFF);

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule